// File: doc/BRIEF.md
# Command Write Spacing and Status Handshake

This block sits between a host and the command register of a network controller. It decides whether each host command write is taken or dropped, and it drives two status flags: `tx_avail` shows that the transmitter is free, and `rx_idle` shows that the receiver is not armed. A command is dropped, and a one-cycle reject strobe is raised, in two cases. The first is a write that comes too soon after the last accepted write. The second is an enable-transmit or enable-receive command that arrives while that channel is still settling after a completion event.

The block uses two timebases. In normal mode the minimum spacing between writes is counted in data-rate clock enables, so it grows as the rate falls. In enhanced mode it is counted in crystal clock cycles and does not depend on the rate. A completion event starts an internal set pulse that lasts a fixed number of data-rate ticks. In normal mode the status flag rises when that pulse starts, and enable commands for that channel are refused until the pulse ends. In enhanced mode the flag rises only when the pulse ends, so the enable command can be written at once.

Top module: `cmd_gate`

## Requirements
- R1: While reset is held and just after it is released, `tx_avail` and `rx_idle` are 1 and `cmd_ok` and `cmd_rej` are 0.
- R2: Each cycle with `cmd_wr` high produces exactly one of `cmd_ok` or `cmd_rej` one clock later. The two strobes are never high together, and neither is raised without a write.
- R3: In normal mode, after an accepted write, any write is rejected until RATE_GAP `rate_en` ticks have passed. A write three cycles after an accepted one is rejected at the default rate.
- R4: In enhanced mode, a write that comes ENH_GAP+1 or more cycles after the last accepted write is accepted, and a closer write is rejected, whatever `rate_en` does.
- R5: A rejected write does not restart the spacing interval. Only accepted writes do.
- R6: Code 8'h03 is enable-transmit and code 8'h04 is enable-receive. An accepted enable-transmit clears `tx_avail` on the next clock, and an accepted enable-receive clears `rx_idle` on the next clock.
- R7: In normal mode, a `tx_done` or `rx_done` pulse that arrives while the matching flag is 0 sets the flag on the next clock. It also opens a window of PULSE_TICKS `rate_en` ticks, during which that channel's enable command is rejected.
- R8: The prohibit window blocks only the matching enable command. Other codes are still accepted if the spacing allows them.
- R9: In enhanced mode, a completion pulse leaves the flag at 0 until PULSE_TICKS `rate_en` ticks have passed, then sets it. An enable command written right after the flag rises is accepted.
- R10: A rejected enable command leaves its status flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low reset |
| rate_en | input | 1 | One-cycle data-rate tick |
| enh_mode | input | 1 | 1 selects enhanced timing |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_code | input | CODE_W | Command code |
| tx_done | input | 1 | Transmit completion event |
| rx_done | input | 1 | Receive completion event |
| tx_avail | output | 1 | Transmitter-available flag |
| rx_idle | output | 1 | Receiver-inhibited flag |
| cmd_ok | output | 1 | Write accepted strobe |
| cmd_rej | output | 1 | Write dropped strobe |

## Verification
The bench sends write pairs spaced one, two, three and many cycles apart in both modes. Three-cycle spacing separates the crystal timebase from the rate timebase, and the accept after a reject shows that rejects do not restart the interval. Completion events are followed by an early enable command, an unrelated command and a late enable command, which tell a channel-specific window apart from a general lockout. In enhanced mode the bench polls until the flag rises and then writes at once, which shows that no window follows.

// File: rtl/cmd_gate.sv
module cmd_gate #(
  parameter int CODE_W      = 8,
  parameter int RATE_GAP    = 2,
  parameter int ENH_GAP     = 2,
  parameter int PULSE_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_en,
  input  logic              enh_mode,
  input  logic              cmd_wr,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              tx_done,
  input  logic              rx_done,
  output logic              tx_avail,
  output logic              rx_idle,
  output logic              cmd_ok,
  output logic              cmd_rej
);
  localparam int GMAX = (RATE_GAP > ENH_GAP) ? RATE_GAP : ENH_GAP;
  localparam int GW   = $clog2(GMAX + 1);
  localparam int PW   = $clog2(PULSE_TICKS + 1);
  localparam logic [CODE_W-1:0] EN_TX = CODE_W'(3);
  localparam logic [CODE_W-1:0] EN_RX = CODE_W'(4);

  logic [GW-1:0] gap_cnt;
  logic [1:0]    stat, lock, done, hit;

  wire gap_busy = gap_cnt != '0;
  assign hit  = {cmd_code == EN_RX, cmd_code == EN_TX};
  assign done = {rx_done, tx_done};
  wire blocked = gap_busy | |(hit & lock);
  wire accept  = cmd_wr & ~blocked;

  assign tx_avail = stat[0];
  assign rx_idle  = stat[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      cmd_ok  <= 1'b0;
      cmd_rej <= 1'b0;
    end else begin
      cmd_ok  <= accept;
      cmd_rej <= cmd_wr & blocked;
      if (accept)
        gap_cnt <= enh_mode ? GW'(ENH_GAP) : GW'(RATE_GAP);
      else if (gap_busy && (enh_mode || rate_en))
        gap_cnt <= gap_cnt - 1'b1;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic          st, act, enm;
    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= 1'b1;
        act <= 1'b0;
        enm <= 1'b0;
        cnt <= '0;
      end else begin
        if (done[ch] && !st && !act) begin
          act <= 1'b1;
          enm <= enh_mode;
          cnt <= PW'(PULSE_TICKS);
          if (!enh_mode) st <= 1'b1;
        end else if (act && rate_en) begin
          cnt <= cnt - 1'b1;
          if (cnt == PW'(1)) begin
            act <= 1'b0;
            if (enm) st <= 1'b1;
          end
        end
        if (accept && hit[ch]) st <= 1'b0;
      end
    end

    assign stat[ch] = st;
    assign lock[ch] = act & ~enm;

    // R7
    win_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && hit[ch] && lock[ch] |=> cmd_rej);
    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ok && $past(hit[ch]) |-> !stat[ch]);
    // R9
    enh_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act && enm |-> !st);
  end

  // R2
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ok && cmd_rej));
  // R2
  resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok || cmd_rej) |-> $past(cmd_wr));
  // R3
  gap_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && gap_busy |=> cmd_rej);
endmodule

// File: tb/cmd_gate_test.sv
module cmd_gate_test;
  logic clk = 0, rst_n = 0, rate_en = 0, enh_mode = 0;
  logic cmd_wr = 0, tx_done = 0, rx_done = 0;
  logic [7:0] cmd_code = '0;
  logic tx_avail, rx_idle, cmd_ok, cmd_rej;
  int checks = 0, fails = 0;
  bit done_flag = 0;
  bit exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  cmd_gate uut (.clk, .rst_n, .rate_en, .enh_mode, .cmd_wr, .cmd_code,
                .tx_done, .rx_done, .tx_avail, .rx_idle, .cmd_ok, .cmd_rej);

  initial forever begin
    repeat (7) begin @(posedge clk); #1 rate_en = 0; end
    @(posedge clk); #1 rate_en = 1;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] code, bit exp, string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    cmd_code = code; cmd_wr = 1;
    @(posedge clk); #1 cmd_wr = 0;
  endtask

  task automatic fin(bit rx);
    if (rx) rx_done = 1; else tx_done = 1;
    @(posedge clk); #1 rx_done = 0; tx_done = 0;
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n && (cmd_ok || cmd_rej)) begin
      check("R2 both", int'(cmd_ok && cmd_rej), 0);
      if (exp_q.size() == 0) check("R2 unexpected", 1, 0);
      else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, int'(cmd_ok), int'(e));
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk);
    check("R1 tx_avail", tx_avail, 1);
    check("R1 rx_idle", rx_idle, 1);
    check("R1 strobes", int'(cmd_ok | cmd_rej), 0);
    idle(0); rst_n = 1;
    idle(2);
    @(negedge clk);
    check("R1 after release", int'({tx_avail, rx_idle, cmd_ok, cmd_rej}), 4'b1100);
    idle(1);

    wr(8'h00, 1, "R3 first");
    wr(8'h00, 0, "R3 back-to-back");
    idle(1);
    wr(8'h00, 0, "R3 three cycles");
    idle(24);
    wr(8'h00, 1, "R3 after ticks");
    idle(24);

    wr(8'h03, 1, "R6 enable tx");
    @(negedge clk); check("R6 tx_avail cleared", tx_avail, 0);
    idle(24);
    wr(8'h04, 1, "R6 enable rx");
    @(negedge clk); check("R6 rx_idle cleared", rx_idle, 0);
    idle(24);

    fin(0);
    @(negedge clk); check("R7 tx_avail set", tx_avail, 1);
    idle(1);
    wr(8'h03, 0, "R7 enable in window");
    @(negedge clk); check("R10 tx_avail kept", tx_avail, 1);
    idle(1);
    wr(8'h00, 1, "R8 other code in window");
    idle(60);
    wr(8'h03, 1, "R7 enable after window");
    @(negedge clk); check("R7 tx_avail cleared", tx_avail, 0);
    idle(24);

    enh_mode = 1;
    idle(2);
    fin(1);
    idle(2);
    @(negedge clk); check("R9 rx_idle still low", rx_idle, 0);
    begin
      int n = 0;
      while (!rx_idle && n < 200) begin @(negedge clk); n++; end
      check("R9 rx_idle rises", rx_idle, 1);
    end
    idle(0);
    wr(8'h04, 1, "R9 enable at once");
    @(negedge clk); check("R9 rx_idle cleared", rx_idle, 0);
    idle(24);

    wr(8'h00, 1, "R4 first");
    wr(8'h00, 0, "R4 one cycle");
    idle(1);
    wr(8'h00, 1, "R5 three after accept");
    idle(1);
    wr(8'h00, 0, "R4 two cycles");
    wr(8'h00, 1, "R4 three cycles");

    idle(5);
    check("R2 all answered", exp_q.size(), 0);
    finish_run();
  end
endmodule